// File: doc/BRIEF.md
# Protection Violation Capture Registers

This block holds the fault-reporting state of a memory protection unit serving up to eight slave ports. The region checking that decides whether an access breaks the rules lives elsewhere; it hands this block a per-port violation strobe, plus the faulting address and a word of access attributes. On every accepted strobe the block stores the address and the attribute word for that port. It also raises a sticky flag for the port. The capture always replaces the previous contents, so each port's registers describe its latest fault.

Software reaches the block through a word-addressed register port with single-cycle write strobes and one-cycle read latency. One control/status word packs the following:
- the eight sticky flags, cleared by writing one;
- a set of read-only configuration fields derived from the build parameters;
- a global enable bit.

While the enable bit is low, the protection function is off, every access is allowed, and strobes are not recorded.

Top module: `prot_fault_capture`

## Requirements
- R1: When the enable bit is one and port n (n < NUM_PORTS) strobes `err_hit[n]`, that port's address register and detail register both load `err_addr[32n+31:32n]` and `err_attr[32n+31:32n]` on that clock edge.
- R2: A new accepted strobe always overwrites the port's capture registers, even when the port's flag is already set; on strobes in consecutive cycles the later one is held.
- R3: The status word is numbered MSB-first (MSB-0 bit k is LSB-0 bit 31-k). The flag for port n sits at MSB-0 bit n, and it sets on the edge that captures an error on port n.
- R4: A write to the status word with a one in a flag position clears that flag, and a zero leaves it unchanged. If a capture on the same port happens in the same cycle as the clearing write, the flag stays set.
- R5: Status word fixed fields (MSB-0), all read-only:
  - bit 8 reads one;
  - bits 12–15 hold REV_LEVEL;
  - bits 16–19 hold NUM_PORTS (1 to 8);
  - bits 20–23 hold the descriptor code: 0000 for 8, 0001 for 12, 0010 for 16;
  - all other non-flag, non-enable bits read zero.
  Writes never change these bits.
- R6: MSB-0 bit 31 (LSB-0 bit 0) of the status word is the writable enable bit. It resets to zero and is mirrored on `prot_enable`. While it is zero, no capture happens and no flag sets.
- R7: Strobes on ports n >= NUM_PORTS are ignored. Those ports' flags and capture registers always read zero.
- R8: After reset all flags, capture registers and the enable bit are zero.
- R9: Register map (byte addresses, word aligned):
  - status word at 0x00;
  - address register of port n at 0x40+8n;
  - detail register of port n at 0x44+8n.
  Any other address reads zero. `reg_rdata` shows the addressed word in the cycle after `reg_rd`, and zero in a cycle not preceded by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_hit | input | 8 | Per-port violation strobe, bit n = port n |
| err_addr | input | 256 | Faulting address, 32 bits per port, port n at [32n+31:32n] |
| err_attr | input | 256 | Faulting access attributes, 32 bits per port |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| prot_enable | output | 1 | Global protection enable (status enable bit) |

## Verification
The bench builds the block with three ports, twelve descriptors and revision level 5. This leaves five strobe lines that correspond to no implemented port. The small port count makes it possible to drive all 256 strobe patterns, covering simultaneous faults on every port subset together with strobes on unimplemented lines. The expected flags, captured words and status fields are computed arithmetically for each pattern. The twelve-descriptor choice checks the middle descriptor code. Clearing the flags only on alternate patterns lets the sweep also cover overwrites of ports whose flags are still set.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int PORT_MAX = 8;
    localparam int WORD_W   = 32;
    localparam int RADDR_W  = 8;

    localparam logic [RADDR_W-1:0] STATUS_ADDR = 8'h00;
    localparam logic [1:0]         SLOT_PAGE   = 2'b01;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] attr;
    } slot_t;

    typedef struct packed {
        logic [PORT_MAX-1:0] flags;
        logic                valid;
    } ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_t;

    function automatic logic [3:0] desc_code(input int ndesc);
        case (ndesc)
            12:      desc_code = 4'd1;
            16:      desc_code = 4'd2;
            default: desc_code = 4'd0;
        endcase
    endfunction

    // Status word, LSB-0 positions of the MSB-0 fields
    function automatic logic [WORD_W-1:0] pack_status(
        input logic [PORT_MAX-1:0] flags,
        input logic                valid,
        input logic [3:0]          rev,
        input logic [3:0]          nports,
        input logic [3:0]          dcode
    );
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < PORT_MAX; i++) begin
            w[WORD_W-1-i] = flags[i];
        end
        w[23]    = 1'b1;
        w[19:16] = rev;
        w[15:12] = nports;
        w[11:8]  = dcode;
        w[0]     = valid;
        return w;
    endfunction

endpackage

// File: rtl/fault_slot.sv
module fault_slot
    import pfc_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              enable,
    input  logic [WORD_W-1:0] addr_in,
    input  logic [WORD_W-1:0] attr_in,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] attr_q
);

    slot_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        take = PRESENT && strobe && enable;
        if (take) begin
            st_d.addr = addr_in;
            st_d.attr = attr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
    assign attr_q = st_q.attr;

    generate
        if (PRESENT) begin : g_live
            // R1, R2: every accepted strobe lands in both registers
            a_r1_capture_pair: assert property (@(posedge clk) disable iff (!rst_n)
                (strobe && enable) |=> (addr_q == $past(addr_in) && attr_q == $past(attr_in)));
            // R6: nothing moves while protection is off
            a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
                (!enable) |=> ($stable(addr_q) && $stable(attr_q)));
        end else begin : g_absent
            // R7: an unimplemented port never holds data
            a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |=> (addr_q == '0 && attr_q == '0));
        end
    endgenerate

endmodule

// File: rtl/fault_status.sv
module fault_status
    import pfc_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_MAX-1:0] hit,
    input  logic                wr_en,
    input  logic [PORT_MAX-1:0] clr_mask,
    input  logic                valid_wr,
    output logic [PORT_MAX-1:0] flags_q,
    output logic                valid_q
);

    localparam logic [PORT_MAX-1:0] PORT_MASK = PORT_MAX'((1 << NUM_PORTS) - 1);

    ctl_t                ctl_d, ctl_q;
    logic [PORT_MAX-1:0] set_v;
    logic [PORT_MAX-1:0] clr_v;

    always_comb begin
        ctl_d = ctl_q;
        set_v = hit & PORT_MASK & {PORT_MAX{ctl_q.valid}};
        clr_v = wr_en ? clr_mask : '0;
        ctl_d.flags = (ctl_q.flags & ~clr_v) | set_v;
        if (wr_en) ctl_d.valid = valid_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flags_q = ctl_q.flags;
    assign valid_q = ctl_q.valid;

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_flag_chk
            // R4: capture beats a coincident clear
            a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[i] && valid_q) |=> flags_q[i]);
            // R4: write-one clears when no capture coincides
            a_r4_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && clr_mask[i] && !(hit[i] && valid_q)) |=> !flags_q[i]);
            // R4: write-zero keeps the flag
            a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[i] && !(wr_en && clr_mask[i])) |=> flags_q[i]);
            // R6: no flag rises while disabled
            a_r6_no_set_off: assert property (@(posedge clk) disable iff (!rst_n)
                (!valid_q && !flags_q[i]) |=> !flags_q[i]);
        end
        for (genvar j = NUM_PORTS; j < PORT_MAX; j++) begin : g_absent_chk
            // R7: flags of missing ports stay low
            a_r7_absent_flag: assert property (@(posedge clk) disable iff (!rst_n)
                hit[j] |=> !flags_q[j]);
        end
    endgenerate

endmodule

// File: rtl/prot_fault_capture.sv
module prot_fault_capture
    import pfc_pkg::*;
#(
    parameter int         NUM_PORTS = 8,
    parameter int         NUM_DESC  = 16,
    parameter logic [3:0] REV_LEVEL = 4'd1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PORT_MAX-1:0]        err_hit,
    input  logic [PORT_MAX*WORD_W-1:0] err_addr,
    input  logic [PORT_MAX*WORD_W-1:0] err_attr,
    input  logic [RADDR_W-1:0]         reg_addr,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [WORD_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]          reg_rdata,
    output logic                       prot_enable
);

    localparam logic [3:0] NPORT_FIELD = 4'(NUM_PORTS);
    localparam logic [3:0] DCODE_FIELD = desc_code(NUM_DESC);

    logic [WORD_W-1:0]   cap_addr [PORT_MAX];
    logic [WORD_W-1:0]   cap_attr [PORT_MAX];
    logic [PORT_MAX-1:0] flags;
    logic                valid;
    logic                status_wr;
    logic [PORT_MAX-1:0] clr_mask;
    logic [WORD_W-1:0]   status_word;

    // flag n occupies MSB-0 bit n, i.e. wdata[31-n]
    always_comb begin
        status_wr = reg_wr && (reg_addr == STATUS_ADDR);
        for (int i = 0; i < PORT_MAX; i++) begin
            clr_mask[i] = reg_wdata[WORD_W-1-i];
        end
    end

    fault_status #(
        .NUM_PORTS (NUM_PORTS)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (err_hit),
        .wr_en    (status_wr),
        .clr_mask (clr_mask),
        .valid_wr (reg_wdata[0]),
        .flags_q  (flags),
        .valid_q  (valid)
    );

    generate
        for (genvar n = 0; n < PORT_MAX; n++) begin : g_slot
            fault_slot #(
                .PRESENT (n < NUM_PORTS)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .strobe  (err_hit[n]),
                .enable  (valid),
                .addr_in (err_addr[n*WORD_W +: WORD_W]),
                .attr_in (err_attr[n*WORD_W +: WORD_W]),
                .addr_q  (cap_addr[n]),
                .attr_q  (cap_attr[n])
            );
        end
    endgenerate

    assign status_word = pack_status(flags, valid, REV_LEVEL, NPORT_FIELD, DCODE_FIELD);
    assign prot_enable = valid;

    // read path
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (reg_rd) begin
            if (reg_addr == STATUS_ADDR) begin
                rd_d.data = status_word;
            end else if (reg_addr[7:6] == SLOT_PAGE && reg_addr[1:0] == 2'b00) begin
                rd_d.data = reg_addr[2] ? cap_attr[reg_addr[5:3]] : cap_addr[reg_addr[5:3]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.data;

    // R9: idle cycles return zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |=> (reg_rdata == '0));
    // R6: the pin mirrors the stored enable written one cycle before
    a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |=> (prot_enable == $past(reg_wdata[0])));
    // R5: the fixed fields never move
    a_r5_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == STATUS_ADDR) |=>
            (reg_rdata[23:8] == {1'b1, 3'b000, REV_LEVEL, NPORT_FIELD, DCODE_FIELD}
             && reg_rdata[7:1] == '0));

endmodule

// File: tb/prot_fault_capture_test.sv
`timescale 1ns/1ps
module prot_fault_capture_test;
    import pfc_pkg::*;

    localparam int         NP  = 3;
    localparam int         ND  = 12;
    localparam logic [3:0] REV = 4'd5;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [PORT_MAX-1:0]        err_hit = '0;
    logic [PORT_MAX*WORD_W-1:0] err_addr = '0;
    logic [PORT_MAX*WORD_W-1:0] err_attr = '0;
    logic [RADDR_W-1:0]         reg_addr = '0;
    logic                       reg_wr = 1'b0;
    logic                       reg_rd = 1'b0;
    logic [WORD_W-1:0]          reg_wdata = '0;
    logic [WORD_W-1:0]          reg_rdata;
    logic                       prot_enable;

    int checks = 0;
    int fails  = 0;

    logic [WORD_W-1:0]   m_addr [PORT_MAX];
    logic [WORD_W-1:0]   m_attr [PORT_MAX];
    logic [PORT_MAX-1:0] m_flags = '0;
    logic                m_valid = 1'b0;

    always #4 clk = ~clk;

    prot_fault_capture #(.NUM_PORTS(NP), .NUM_DESC(ND), .REV_LEVEL(REV)) uut (
        .clk(clk), .rst_n(rst_n), .err_hit(err_hit), .err_addr(err_addr),
        .err_attr(err_attr), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_enable(prot_enable)
    );

    function automatic logic [31:0] mk_addr(int n, int salt);
        return 32'h4000_0000 + 32'(salt) * 32'h100 + 32'(n) * 32'h10 + 32'h4;
    endfunction
    function automatic logic [31:0] mk_attr(int n, int salt);
        return ~mk_addr(n, salt) ^ (32'(n) << 24);
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] w;
        w = 32'h0080_0000 | (32'(REV) << 16) | (32'(NP) << 12) | (32'd1 << 8) | 32'(m_valid);
        for (int i = 0; i < PORT_MAX; i++) if (m_flags[i]) w = w | (32'h8000_0000 >> i);
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0; v = reg_rdata;
    endtask

    // one cycle of stimulus; model follows the requirements
    task automatic step(logic [7:0] hits, int salt, logic wr, logic [31:0] wd);
        logic [PORT_MAX-1:0] setv;
        for (int n = 0; n < PORT_MAX; n++) begin
            err_addr[n*32 +: 32] = mk_addr(n, salt);
            err_attr[n*32 +: 32] = mk_attr(n, salt);
        end
        err_hit = hits; reg_addr = 8'h00; reg_wr = wr; reg_wdata = wd;
        setv = '0;
        for (int n = 0; n < NP; n++) begin
            if (hits[n] && m_valid) begin
                setv[n] = 1'b1;
                m_addr[n] = mk_addr(n, salt);
                m_attr[n] = mk_attr(n, salt);
            end
        end
        for (int n = 0; n < PORT_MAX; n++) if (wr && wd[31-n]) m_flags[n] = 1'b0;
        m_flags = m_flags | setv;
        if (wr) m_valid = wd[0];
        @(posedge clk); @(negedge clk);
        err_hit = '0; reg_wr = 1'b0;
    endtask

    task automatic check_all(string tag);
        logic [31:0] v;
        rd(8'h00, v); check({tag, " R3 R5 status"}, v, exp_status());
        for (int n = 0; n < PORT_MAX; n++) begin
            rd(8'(8'h40 + 8 * n), v);
            check({tag, " R1 R7 addr"}, v, (n < NP) ? m_addr[n] : 32'h0);
            rd(8'(8'h44 + 8 * n), v);
            check({tag, " R1 R7 detail"}, v, (n < NP) ? m_attr[n] : 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int n = 0; n < PORT_MAX; n++) begin m_addr[n] = '0; m_attr[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        check_all("R8 reset");
        check("R8 enable pin", 32'(prot_enable), 32'h0);

        // R6: strobes while disabled do nothing
        step(8'hFF, 1, 1'b0, 32'h0);
        check_all("R6 disabled");

        // R5: writes to read-only bits are dropped
        step(8'h00, 2, 1'b1, 32'h00FF_FFFE);
        check_all("R5 ro write");

        // R6: enable
        step(8'h00, 3, 1'b1, 32'h0000_0001);
        check("R6 enable pin", 32'(prot_enable), 32'h1);

        // R1 R2 R3 R7: all strobe patterns, clearing only after odd ones
        for (int p = 0; p < 256; p++) begin
            step(8'(p), 16 + p, 1'b0, 32'h0);
            check_all("R1 R2 sweep");
            if (p % 2 == 1) begin
                step(8'h00, 0, 1'b1, 32'hFF00_0001);
                rd(8'h00, v); check("R4 clear all", v, exp_status());
            end
        end

        // R2: back-to-back on port 1, later wins
        step(8'h02, 300, 1'b0, 32'h0);
        step(8'h02, 301, 1'b0, 32'h0);
        check_all("R2 back to back");

        // R4: clear coincides with new error on port 0
        step(8'h01, 302, 1'b1, 32'hFF00_0001);
        check_all("R4 set wins");

        // R4: writing zeros keeps flags
        step(8'h06, 303, 1'b0, 32'h0);
        step(8'h00, 0, 1'b1, 32'h0000_0001);
        check_all("R4 zero keeps");

        // R4: clear only port 2 (MSB-0 bit 2 = LSB-0 bit 29)
        step(8'h00, 0, 1'b1, 32'h2000_0001);
        check_all("R4 single clear");

        // R6: disable, then strobes ignored
        step(8'h00, 0, 1'b1, 32'h0000_0000);
        step(8'h07, 304, 1'b0, 32'h0);
        check_all("R6 disabled again");
        check("R6 enable pin low", 32'(prot_enable), 32'h0);

        // R9: unmapped addresses and idle cycle
        rd(8'h04, v); check("R9 unmapped 04", v, 32'h0);
        rd(8'h20, v); check("R9 unmapped 20", v, 32'h0);
        rd(8'h42, v); check("R9 misaligned", v, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R9 idle zero", reg_rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule